// File: doc/BRIEF.md
# OTP Programming Unlock and Address Range Guard

This block stands between a byte-wide register write path and a one-time-programmable memory of 4 KB. It watches register writes to one password address and keeps a programming-enable qualifier. The qualifier opens only after two fixed password bytes arrive there in order. Any number of writes to other register addresses may fall between the two bytes, and there is no limit on the delay. Any write to the password address that breaks the sequence closes programming again.

For memory accesses, the block collects a two-byte address. A transfer start clears it, then the low byte arrives, then the high byte. Addresses at or above the memory size are out of range. Reads there are forced to zero through a level output. Data-byte writes arrive on a valid/ready stream. They pass to the memory's valid/ready write port only when programming is unlocked and the address is complete and in range. Otherwise they are accepted and dropped. When a write is passed on, the memory's back-pressure reaches the source unchanged. When a write is dropped, the source is never stalled.

Top module: `otp_guard`

## Requirements
- R1: After reset, `prog_en` is 0, `rd_zero` is 1 and `mw_valid` is 0.
- R2: A write of `PW_BYTE0` to address `PW_ADDR` (default 0x0F), followed by a write of `PW_BYTE1` there, sets `prog_en` from the clock edge that takes the second write. Idle cycles and writes to other addresses may fall between the two bytes.
- R3: While locked or holding a correct first byte, a write to `PW_ADDR` of any other byte returns to locked. The one exception is a repeat of `PW_BYTE0` in the waiting state, which keeps the block waiting for the second byte.
- R4: While unlocked, any write to `PW_ADDR` clears `prog_en` at that edge. The byte `PW_BYTE0` leaves the block waiting for the second byte. Any other byte leaves it locked.
- R5: Writes to any address other than `PW_ADDR` never change `prog_en`.
- R6: After an `otp_start` pulse, the first accepted `oa_valid` byte is the address bits [7:0] and the second is bits [15:8]. Further bytes are ignored until the next `otp_start`. A byte in the same cycle as `otp_start` is ignored.
- R7: `rd_zero` is 1 whenever the address is incomplete or is 0x1000 or above. It is 0 for a complete address from 0x0000 to 0x0FFF.
- R8: With `prog_en` set and an in-range address, `ow_valid` shows directly on `mw_valid`. `mw_addr` is the address bits [11:0] and `mw_data` equals `ow_data`.
- R9: When locked or out of range, `mw_valid` stays 0 and `ow_ready` is 1, so the write byte is dropped.
- R10: While forwarding, `ow_ready` equals `mw_ready`. `mw_valid` never depends on `mw_ready`, so a stalled byte stays offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| otp_start | input | 1 | Start of a memory transfer; clears the address |
| oa_valid | input | 1 | Address byte strobe |
| oa_byte | input | 8 | Address byte, low byte first |
| ow_valid | input | 1 | Write data byte valid |
| ow_ready | output | 1 | Write data byte accepted |
| ow_data | input | 8 | Write data byte |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write ready |
| mw_addr | output | 12 | Memory write address |
| mw_data | output | 8 | Memory write data |
| prog_en | output | 1 | Programming enabled |
| rd_zero | output | 1 | Force read data to zero |

## Verification
The assertions assume that `mw_ready` is always a known level. They also assume that register writes and address bytes are single-cycle strobes that start counting only after reset is released. The bench drives every input on the falling clock edge and keeps `otp_start` apart from address bytes, except in the one check that tests them together. It holds `ow_valid` with stable data while it samples the combinational stream outputs.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
  typedef enum logic [1:0] {
    PW_LOCKED = 2'd0,
    PW_HALF   = 2'd1,
    PW_OPEN   = 2'd2
  } pw_state_e;
endpackage

// File: rtl/otp_pw_fsm.sv
module otp_pw_fsm #(
  parameter int unsigned REG_AW  = 8,
  parameter logic [7:0]  PW_ADDR = 8'h0F,
  parameter logic [7:0]  PW_BYTE0 = 8'hA5,
  parameter logic [7:0]  PW_BYTE1 = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              unlocked
);
  import otp_guard_pkg::*;

  pw_state_e st_q, st_d;
  logic      hit;

  assign hit = we && (addr == REG_AW'(PW_ADDR));

  always_comb begin
    st_d = st_q;
    if (hit) begin
      unique case (st_q)
        PW_LOCKED: st_d = (wdata == PW_BYTE0) ? PW_HALF : PW_LOCKED;
        PW_HALF: begin
          if (wdata == PW_BYTE1)      st_d = PW_OPEN;
          else if (wdata == PW_BYTE0) st_d = PW_HALF;
          else                        st_d = PW_LOCKED;
        end
        PW_OPEN:   st_d = (wdata == PW_BYTE0) ? PW_HALF : PW_LOCKED;
        default:   st_d = PW_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PW_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == PW_OPEN);
endmodule

// File: rtl/otp_addr_cap.sv
module otp_addr_cap #(
  parameter int unsigned MEM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic [15:0] addr,
  output logic        in_range
);
  localparam logic [16:0] LIMIT = 17'(MEM_BYTES);

  logic [7:0] lo_q, hi_q;
  logic       have_lo_q, full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      have_lo_q <= 1'b0;
      full_q    <= 1'b0;
    end else if (start) begin
      have_lo_q <= 1'b0;
      full_q    <= 1'b0;
    end else if (byte_vld && !full_q) begin
      if (!have_lo_q) begin
        lo_q      <= byte_in;
        have_lo_q <= 1'b1;
      end else begin
        hi_q   <= byte_in;
        full_q <= 1'b1;
      end
    end
  end

  assign addr     = {hi_q, lo_q};
  assign in_range = full_q && ({1'b0, hi_q, lo_q} < LIMIT);
endmodule

// File: rtl/otp_wr_gate.sv
module otp_wr_gate #(
  parameter int unsigned AW = 12
) (
  input  logic          permit,
  input  logic [15:0]   addr,
  input  logic          ow_valid,
  output logic          ow_ready,
  input  logic [7:0]    ow_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [7:0]    mw_data
);
  assign mw_valid = ow_valid && permit;
  assign ow_ready = permit ? mw_ready : 1'b1;
  assign mw_addr  = addr[AW-1:0];
  assign mw_data  = ow_data;
endmodule

// File: rtl/otp_guard.sv
module otp_guard #(
  parameter logic [7:0]  PW_ADDR   = 8'h0F,
  parameter logic [7:0]  PW_BYTE0  = 8'hA5,
  parameter logic [7:0]  PW_BYTE1  = 8'h3C,
  parameter int unsigned MEM_BYTES = 4096,
  localparam int unsigned AW       = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          otp_start,
  input  logic          oa_valid,
  input  logic [7:0]    oa_byte,
  input  logic          ow_valid,
  output logic          ow_ready,
  input  logic [7:0]    ow_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [7:0]    mw_data,
  output logic          prog_en,
  output logic          rd_zero
);
  logic [15:0] addr;
  logic        in_range;

  otp_pw_fsm #(
    .REG_AW(8), .PW_ADDR(PW_ADDR), .PW_BYTE0(PW_BYTE0), .PW_BYTE1(PW_BYTE1)
  ) pw_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .unlocked(prog_en)
  );

  otp_addr_cap #(.MEM_BYTES(MEM_BYTES)) adr_i (
    .clk(clk), .rst_n(rst_n), .start(otp_start), .byte_vld(oa_valid),
    .byte_in(oa_byte), .addr(addr), .in_range(in_range)
  );

  otp_wr_gate #(.AW(AW)) gate_i (
    .permit(prog_en && in_range), .addr(addr),
    .ow_valid(ow_valid), .ow_ready(ow_ready), .ow_data(ow_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data)
  );

  assign rd_zero = !in_range;
endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk #(
  parameter logic [7:0] PW_ADDR  = 8'h0F,
  parameter logic [7:0] PW_BYTE0 = 8'hA5,
  parameter logic [7:0] PW_BYTE1 = 8'h3C,
  parameter int unsigned AW      = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_addr,
  input logic [7:0]    cfg_wdata,
  input logic          otp_start,
  input logic          oa_valid,
  input logic [7:0]    oa_byte,
  input logic          ow_valid,
  input logic          ow_ready,
  input logic [7:0]    ow_data,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [7:0]    mw_data,
  input logic          prog_en,
  input logic          rd_zero
);
  // R2: programming opens only right after a correct second byte
  a_r2_open_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en) |-> $past(cfg_we && cfg_addr == PW_ADDR && cfg_wdata == PW_BYTE1));

  // R3: a foreign byte at the password address always locks
  a_r3_bad_byte_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == PW_ADDR && cfg_wdata != PW_BYTE0 && cfg_wdata != PW_BYTE1)
    |=> !prog_en);

  // R4: any password write while open revokes
  a_r4_revoke: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && cfg_we && cfg_addr == PW_ADDR) |=> !prog_en);

  // R5: other addresses leave the qualifier alone
  a_r5_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == PW_ADDR) |=> $stable(prog_en));

  // R6: a new transfer starts with no usable address
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    otp_start |=> rd_zero);

  // R8: nothing reaches the memory unless unlocked and in range
  a_r8_fwd_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (prog_en && !rd_zero && ow_valid && mw_data == ow_data));

  // R9: dropped bytes never stall the source
  a_r9_drop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_en || rd_zero) |-> (ow_ready && !mw_valid));

  // R10: memory back-pressure reaches the source
  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |-> !ow_ready);
endmodule

bind otp_guard otp_guard_chk #(
  .PW_ADDR(PW_ADDR), .PW_BYTE0(PW_BYTE0), .PW_BYTE1(PW_BYTE1), .AW(AW)
) chk_i (.*);

// File: tb/otp_guard_tb_top.sv
module otp_guard_tb_top;
  localparam logic [7:0] PWA = 8'h0F;
  localparam logic [7:0] P0  = 8'hA5;
  localparam logic [7:0] P1  = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, otp_start = 1'b0, oa_valid = 1'b0, ow_valid = 1'b0, mw_ready = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, oa_byte = '0, ow_data = '0;
  logic ow_ready, mw_valid, prog_en, rd_zero;
  logic [11:0] mw_addr;
  logic [7:0]  mw_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .otp_start(otp_start), .oa_valid(oa_valid), .oa_byte(oa_byte),
    .ow_valid(ow_valid), .ow_ready(ow_ready), .ow_data(ow_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .prog_en(prog_en), .rd_zero(rd_zero)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    @(negedge clk); otp_start = 1'b1;
    @(negedge clk); otp_start = 1'b0; oa_valid = 1'b1; oa_byte = a[7:0];
    @(negedge clk); oa_byte = a[15:8];
    @(negedge clk); oa_valid = 1'b0;
  endtask

  task automatic unlock();
    reg_wr(PWA, P0); reg_wr(PWA, P1);
  endtask

  task automatic t_reset();
    chk("R1", "prog_en", 16'(prog_en), 16'd0);
    chk("R1", "rd_zero", 16'(rd_zero), 16'd1);
    chk("R1", "mw_valid", 16'(mw_valid), 16'd0);
  endtask

  task automatic t_unlock();
    reg_wr(PWA, P0);
    chk("R2", "after first byte", 16'(prog_en), 16'd0);
    reg_wr(8'h05, 8'h77);
    repeat (10) @(negedge clk);
    reg_wr(PWA, P1);
    chk("R2", "after second byte with gap", 16'(prog_en), 16'd1);
  endtask

  task automatic t_other();
    reg_wr(8'h0E, P0); reg_wr(8'h10, 8'h00); reg_wr(8'h1F, P1);
    chk("R5", "other addresses keep unlock", 16'(prog_en), 16'd1);
  endtask

  task automatic t_revoke();
    reg_wr(PWA, 8'h00);
    chk("R4", "wrong byte revokes", 16'(prog_en), 16'd0);
    reg_wr(PWA, P1);
    chk("R4", "second byte alone after revoke", 16'(prog_en), 16'd0);
    unlock();
    reg_wr(PWA, P0);
    chk("R4", "first byte revokes", 16'(prog_en), 16'd0);
    reg_wr(PWA, P1);
    chk("R4", "first byte then second reopens", 16'(prog_en), 16'd1);
  endtask

  task automatic t_wrong();
    reg_wr(PWA, 8'h11);
    reg_wr(PWA, 8'h11); reg_wr(PWA, P1);
    chk("R3", "bad byte then second", 16'(prog_en), 16'd0);
    reg_wr(PWA, P0); reg_wr(PWA, P0); reg_wr(PWA, P1);
    chk("R3", "repeated first byte", 16'(prog_en), 16'd1);
    reg_wr(PWA, P0); reg_wr(PWA, 8'h22); reg_wr(PWA, P1);
    chk("R3", "bad second byte", 16'(prog_en), 16'd0);
  endtask

  task automatic t_addr();
    set_addr(16'h0FFF);
    chk("R7", "0x0FFF in range", 16'(rd_zero), 16'd0);
    set_addr(16'h1000);
    chk("R7", "0x1000 out of range", 16'(rd_zero), 16'd1);
    @(negedge clk); otp_start = 1'b1;
    @(negedge clk); otp_start = 1'b0; oa_valid = 1'b1; oa_byte = 8'h00;
    @(negedge clk); oa_valid = 1'b0;
    chk("R7", "incomplete address", 16'(rd_zero), 16'd1);
    set_addr(16'h0123);
    @(negedge clk); oa_valid = 1'b1; oa_byte = 8'hFF;
    @(negedge clk); oa_valid = 1'b0;
    chk("R6", "extra byte ignored, rd_zero", 16'(rd_zero), 16'd0);
    chk("R6", "extra byte ignored, addr", 16'(mw_addr), 16'h0123);
    @(negedge clk); otp_start = 1'b1; oa_valid = 1'b1; oa_byte = 8'h45;
    @(negedge clk); otp_start = 1'b0; oa_byte = 8'h06;
    @(negedge clk); oa_byte = 8'h00;
    @(negedge clk); oa_valid = 1'b0;
    chk("R6", "byte with start ignored", 16'(mw_addr), 16'h0006);
  endtask

  task automatic t_fwd();
    unlock();
    set_addr(16'h0ABC);
    @(negedge clk); ow_valid = 1'b1; ow_data = 8'h5A; mw_ready = 1'b1;
    #2;
    chk("R8", "mw_valid", 16'(mw_valid), 16'd1);
    chk("R8", "mw_addr", 16'(mw_addr), 16'h0ABC);
    chk("R8", "mw_data", 16'(mw_data), 16'h005A);
    chk("R10", "ready passes high", 16'(ow_ready), 16'd1);
    mw_ready = 1'b0;
    #2;
    chk("R10", "ready passes low", 16'(ow_ready), 16'd0);
    chk("R10", "valid held under stall", 16'(mw_valid), 16'd1);
    @(negedge clk); ow_valid = 1'b0;
  endtask

  task automatic t_drop();
    set_addr(16'h2000);
    @(negedge clk); ow_valid = 1'b1; ow_data = 8'h99; mw_ready = 1'b0;
    #2;
    chk("R9", "out of range mw_valid", 16'(mw_valid), 16'd0);
    chk("R9", "out of range ow_ready", 16'(ow_ready), 16'd1);
    @(negedge clk); ow_valid = 1'b0;
    set_addr(16'h0010);
    reg_wr(PWA, 8'h00);
    @(negedge clk); ow_valid = 1'b1;
    #2;
    chk("R9", "locked mw_valid", 16'(mw_valid), 16'd0);
    chk("R9", "locked ow_ready", 16'(ow_ready), 16'd1);
    @(negedge clk); ow_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unlock();
    t_other();
    t_revoke();
    t_wrong();
    t_addr();
    t_fwd();
    t_drop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule